// File: doc/BRIEF.md
# Dual-Source Reset Sequencer with Host Bus Gate

This block turns two reset sources into a set of separate reset domains for a wireless network controller. One source is an external reset pin, sampled on the core clock. A pulse on the pin only counts once it has been seen low for a minimum number of consecutive cycles. The other source is a software reset bit that lives inside this block. The host sets it and clears it with plain writes. Each register group and state-machine domain has its own active-low reset output. A fixed per-group mask decides which source drives each output. One group, the retained configuration registers, is left alone by both sources.

The block also owns the host-facing slave-access gate. While a qualified pin reset is active, the host output drivers are disabled. Any slave cycle in progress is dropped on the same edge the reset takes effect, and a one-cycle abort pulse reports it. After the pin is released, a holdoff counter keeps the gate closed for a fixed number of clocks, so the host cannot start a new access until the counter has run out. The software reset clears the bit-holding register groups of the bus interface. It does not touch the controller core, the sleep logic or the plug-and-play configuration logic.

Top module: `rst_domain_ctrl`

## Requirements
- R1: A pin pulse shorter than MIN_PULSE (8) consecutive low samples has no effect: hw_rst_active stays 0, all grp_rst_n bits keep their value and an open slave cycle continues.
- R2: On the clock edge that takes the MIN_PULSE-th consecutive low sample, hw_rst_active goes to 1. grp_rst_n bits 0 (bus interface and arbiter), 1 (system registers), 2 (memory-interface registers), 3 (controller core), 4 (sleep logic) and 5 (plug-and-play configuration) then all read 0. All of these are released on the first edge that samples the pin high.
- R3: host_oe is 0 whenever hw_rst_active is 1, and 1 otherwise.
- R4: A slave cycle open when the qualified pin reset takes effect is dropped on that same edge (slv_active goes to 0). slv_abort is 1 for exactly the one following cycle.
- R5: After the pin is released, slv_ready stays 0 for HOLDOFF (4) cycles. A request held from the release edge starts a slave cycle (slv_active goes to 1) on the fourth edge after the release edge, and not earlier. A started cycle ends without abort on an edge that samples slv_end.
- R6: sw_rst_bit takes sw_wr_data on an edge that samples sw_wr_en and keeps its value otherwise, so it survives its own reset. A qualified pin reset clears it, and writes during a pin reset are ignored.
- R7: While sw_rst_bit is 1, grp_rst_n bits 0 and 1 read 0, and bits 2 to 5 are not asserted by it.
- R8: grp_rst_n bit 6 (retained registers) is 1 at all times, under either reset source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | External reset pin, active low, synchronous to clk |
| sw_wr_en | input | 1 | Host write strobe for the software reset bit |
| sw_wr_data | input | 1 | Value written to the software reset bit |
| slv_req | input | 1 | Host requests a slave access, held until accepted |
| slv_end | input | 1 | Host ends the open slave access |
| hw_rst_active | output | 1 | Qualified pin reset is in effect |
| sw_rst_bit | output | 1 | Current software reset bit |
| grp_rst_n | output | 7 | Active-low reset per register group (index per R2, R8) |
| host_oe | output | 1 | Host output drivers may be enabled |
| slv_ready | output | 1 | Holdoff has expired; new slave accesses may start |
| slv_active | output | 1 | A slave access is open |
| slv_abort | output | 1 | One-cycle pulse: an open access was dropped by reset |

## Verification
The bench builds the block with its default values, MIN_PULSE of 8 and HOLDOFF of 4. With these values a 7-cycle pin pulse and an 8-cycle pin pulse sit exactly on either side of the qualifying boundary. The holdoff is also short enough that each of its cycles can be probed one by one. A behavioural reference model counts consecutive low samples and holdoff cycles as plain integers and is compared with every output on every clock. Directed checks cover the start edge of a slave access held from the release, an abort during a qualified pulse, and software writes that land inside a pin reset.

// File: rtl/rdc_pkg.sv
// Package: shared constants for the reset domain sequencer.
// Assumes: group indices are fixed; the consumers of grp_rst_n decode them.
package rdc_pkg;
    localparam int NGRP = 7;

    typedef enum int {
        GRP_BIU    = 0,
        GRP_SYSREG = 1,
        GRP_MEMIF  = 2,
        GRP_CTRL   = 3,
        GRP_SLEEP  = 4,
        GRP_CFG    = 5,
        GRP_RETAIN = 6
    } grp_e;

    // Which groups the qualified pin reset clears.
    localparam logic [NGRP-1:0] HW_MASK = 7'b011_1111;
    // Which groups the software reset bit clears.
    localparam logic [NGRP-1:0] SW_MASK = 7'b000_0011;
endpackage

// File: rtl/rdc_pin_qual.sv
// Module: pin reset qualifier.
// Keeps a short history of pin samples and reports a reset once
// MIN_PULSE consecutive low samples have been seen; the reset holds
// until the pin is sampled high. The pin itself is the only reset here,
// so the history settles after MIN_PULSE cycles of a low pin.
// Assumes: rst_pin_n is synchronous to clk; MIN_PULSE >= 2.
module rdc_pin_qual #(
    parameter int MIN_PULSE = 8
) (
    input  logic clk,
    input  logic rst_pin_n,
    output logic act_q,
    output logic act_nxt
);
    localparam int HW = MIN_PULSE - 1;

    logic [HW-1:0]        hist_q;
    logic [MIN_PULSE-1:0] hist_nxt;

    // Build the window of the newest MIN_PULSE samples and the next state.
    always_comb begin
        hist_nxt = {hist_q, rst_pin_n};
        act_nxt  = (hist_nxt == '0) || (act_q && !rst_pin_n);
    end

    // Shift in the pin sample and register the qualified reset.
    always_ff @(posedge clk) begin
        hist_q <= hist_nxt[HW-1:0];
        act_q  <= act_nxt;
    end
endmodule

// File: rtl/rdc_swbit.sv
// Module: software reset bit holder.
// Holds the host-written reset bit. The bit is not cleared by its own
// reset; only the qualified pin reset clears it, and host writes that
// arrive while the pin reset is in effect are dropped.
// Assumes: act_nxt is the next-cycle qualified pin reset.
module rdc_swbit (
    input  logic clk,
    input  logic act_nxt,
    input  logic wr_en,
    input  logic wr_data,
    output logic bit_q
);
    // Clear on pin reset, otherwise follow host writes.
    always_ff @(posedge clk) begin
        if (act_nxt) begin
            bit_q <= 1'b0;
        end else if (wr_en) begin
            bit_q <= wr_data;
        end
    end
endmodule

// File: rtl/rdc_domain_dec.sv
// Module: reset domain decoder.
// Maps the two reset sources onto one active-low reset per register
// group, using the per-group source masks from the package. A group
// with neither mask bit set never sees a reset.
// Assumes: both sources are registered upstream, so outputs are glitch free.
module rdc_domain_dec
    import rdc_pkg::*;
(
    input  logic            hw_act,
    input  logic            sw_act,
    output logic [NGRP-1:0] grp_rst_n
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (HW_MASK[g] || SW_MASK[g]) begin : g_driven
            // Combine the sources that this group listens to.
            always_comb begin
                grp_rst_n[g] = !((HW_MASK[g] && hw_act) || (SW_MASK[g] && sw_act));
            end
        end else begin : g_retained
            // Retained group: no source reaches it.
            always_comb begin
                grp_rst_n[g] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdc_slave_gate.sv
// Module: host slave-access gate.
// Counts HOLDOFF clocks after the pin reset ends before new slave
// accesses may start. Runs a two-state slave tracker that the pin
// reset forces idle, and reports a dropped access with a one-cycle pulse.
// Assumes: HOLDOFF >= 1; slv_req is held by the host until accepted.
module rdc_slave_gate #(
    parameter int HOLDOFF = 4
) (
    input  logic clk,
    input  logic act_nxt,
    input  logic slv_req,
    input  logic slv_end,
    output logic slv_ready,
    output logic slv_active,
    output logic slv_abort
);
    localparam int CW = $clog2(HOLDOFF + 1);
    localparam logic [CW-1:0] HOLD_END = CW'(HOLDOFF);

    typedef enum logic {SLV_IDLE = 1'b0, SLV_OPEN = 1'b1} slv_st_e;

    logic [CW-1:0] hold_q;
    slv_st_e       st_q;
    slv_st_e       st_nxt;
    logic          abort_q;

    // The gate opens only once the holdoff count has run out.
    always_comb begin
        slv_ready = (hold_q == HOLD_END);
    end

    // Next slave state: reset wins, then end, then a gated start.
    always_comb begin
        st_nxt = st_q;
        if (act_nxt) begin
            st_nxt = SLV_IDLE;
        end else if (st_q == SLV_OPEN) begin
            if (slv_end) begin
                st_nxt = SLV_IDLE;
            end
        end else if (slv_req && slv_ready) begin
            st_nxt = SLV_OPEN;
        end
    end

    // Holdoff counter: cleared by the pin reset, saturates at HOLDOFF.
    always_ff @(posedge clk) begin
        if (act_nxt) begin
            hold_q <= '0;
        end else if (hold_q != HOLD_END) begin
            hold_q <= hold_q + CW'(1);
        end
    end

    // Slave state register and abort pulse.
    always_ff @(posedge clk) begin
        st_q    <= st_nxt;
        abort_q <= act_nxt && (st_q == SLV_OPEN);
    end

    assign slv_active = (st_q == SLV_OPEN);
    assign slv_abort  = abort_q;
endmodule

// File: rtl/rst_domain_ctrl.sv
// Module: dual-source reset sequencer with host bus gate (top).
// Qualifies the reset pin, holds the software reset bit, decodes the
// per-group reset outputs, disables host drivers during pin reset and
// gates host slave accesses through a post-release holdoff.
// Assumes: all inputs are synchronous to clk; the pin is held low for
// at least MIN_PULSE cycles at power-up before outputs are meaningful.
module rst_domain_ctrl #(
    parameter int MIN_PULSE = 8,
    parameter int HOLDOFF   = 4
) (
    input  logic       clk,
    input  logic       rst_pin_n,
    input  logic       sw_wr_en,
    input  logic       sw_wr_data,
    input  logic       slv_req,
    input  logic       slv_end,
    output logic       hw_rst_active,
    output logic       sw_rst_bit,
    output logic [6:0] grp_rst_n,
    output logic       host_oe,
    output logic       slv_ready,
    output logic       slv_active,
    output logic       slv_abort
);
    logic act_q;
    logic act_nxt;

    rdc_pin_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
        .clk       (clk),
        .rst_pin_n (rst_pin_n),
        .act_q     (act_q),
        .act_nxt   (act_nxt)
    );

    rdc_swbit u_swbit (
        .clk     (clk),
        .act_nxt (act_nxt),
        .wr_en   (sw_wr_en),
        .wr_data (sw_wr_data),
        .bit_q   (sw_rst_bit)
    );

    rdc_domain_dec u_dec (
        .hw_act    (act_q),
        .sw_act    (sw_rst_bit),
        .grp_rst_n (grp_rst_n)
    );

    rdc_slave_gate #(.HOLDOFF(HOLDOFF)) u_gate (
        .clk        (clk),
        .act_nxt    (act_nxt),
        .slv_req    (slv_req),
        .slv_end    (slv_end),
        .slv_ready  (slv_ready),
        .slv_active (slv_active),
        .slv_abort  (slv_abort)
    );

    // Host drivers are released only outside a qualified pin reset.
    always_comb begin
        hw_rst_active = act_q;
        host_oe       = !act_q;
    end
endmodule

// File: rtl/rst_domain_ctrl_chk.sv
// Module: property checker for rst_domain_ctrl, bound to the top.
// Assumes: checks start after the first qualified pin reset.
module rst_domain_ctrl_chk #(
    parameter int HOLDOFF = 4
) (
    input logic       clk,
    input logic       sw_wr_en,
    input logic       hw_rst_active,
    input logic       sw_rst_bit,
    input logic [6:0] grp_rst_n,
    input logic       slv_active,
    input logic       slv_abort
);
    logic        seen = 1'b0;
    logic [31:0] since_rel = '0;

    // Enable checking once a pin reset has defined the state.
    always_ff @(posedge clk) begin
        seen <= seen || hw_rst_active;
    end

    // Count cycles since the pin reset ended, saturating.
    always_ff @(posedge clk) begin
        if (hw_rst_active) begin
            since_rel <= '0;
        end else if (since_rel != 32'hFFFF_FFFF) begin
            since_rel <= since_rel + 32'd1;
        end
    end

    AST_DROP_ON_RESET: assert property (@(posedge clk) disable iff (!seen)
        $rose(hw_rst_active) |-> !slv_active); // R4
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!seen)
        slv_abort |=> !slv_abort); // R4
    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!seen)
        $rose(slv_active) |-> (since_rel >= 32'(HOLDOFF))); // R5
    AST_SWBIT_KEEPS: assert property (@(posedge clk) disable iff (!seen)
        (!hw_rst_active && !sw_wr_en) |=> (hw_rst_active || $stable(sw_rst_bit))); // R6
    AST_SW_SPARES_CORE: assert property (@(posedge clk) disable iff (!seen)
        (sw_rst_bit && !hw_rst_active) |-> (grp_rst_n[5:2] == 4'hF)); // R7
endmodule

bind rst_domain_ctrl rst_domain_ctrl_chk #(.HOLDOFF(HOLDOFF)) u_chk (
    .clk           (clk),
    .sw_wr_en      (sw_wr_en),
    .hw_rst_active (hw_rst_active),
    .sw_rst_bit    (sw_rst_bit),
    .grp_rst_n     (grp_rst_n),
    .slv_active    (slv_active),
    .slv_abort     (slv_abort)
);

// File: tb/rst_domain_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_domain_ctrl_tb_top;
    localparam int MINP = 8;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_pin_n = 1'b0;
    logic       sw_wr_en = 1'b0, sw_wr_data = 1'b0;
    logic       slv_req = 1'b0, slv_end = 1'b0;
    logic       hw_rst_active, sw_rst_bit, host_oe, slv_ready, slv_active, slv_abort;
    logic [6:0] grp_rst_n;

    rst_domain_ctrl #(.MIN_PULSE(MINP), .HOLDOFF(HOLD)) dut_i (
        .clk(clk), .rst_pin_n(rst_pin_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .slv_req(slv_req), .slv_end(slv_end), .hw_rst_active(hw_rst_active),
        .sw_rst_bit(sw_rst_bit), .grp_rst_n(grp_rst_n), .host_oe(host_oe),
        .slv_ready(slv_ready), .slv_active(slv_active), .slv_abort(slv_abort)
    );

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    task automatic chk(input string tag, input string nm, input logic [6:0] a, input logic [6:0] e);
        vecs++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, nm, a, e);
        end
    endtask

    // Behavioural reference model, updated on each edge.
    int lowcnt = 0, m_cnt = 0;
    bit m_act = 0, m_sw = 0, m_active = 0, m_abort = 0, valid = 0;

    always @(posedge clk) begin
        bit nact;
        if (!rst_pin_n) lowcnt++; else lowcnt = 0;
        nact = (lowcnt >= MINP);
        m_abort = nact && m_active;
        if (nact) begin
            m_sw = 0; m_cnt = 0; m_active = 0;
        end else begin
            if (sw_wr_en) m_sw = sw_wr_data;
            if (m_active) begin
                if (slv_end) m_active = 0;
            end else if (slv_req && m_cnt == HOLD) begin
                m_active = 1;
            end
            if (m_cnt < HOLD) m_cnt++;
        end
        m_act = nact;
        if (nact) valid = 1;
        #1;
        if (valid && !done) begin
            chk("R1", "hw_rst_active", {6'd0, hw_rst_active}, {6'd0, m_act});
            chk("R2", "grp_rst_n[5:2]", {3'd0, grp_rst_n[5:2]}, {3'd0, {4{!m_act}}});
            chk("R7", "grp_rst_n[1:0]", {5'd0, grp_rst_n[1:0]}, {5'd0, {2{!(m_act || m_sw)}}});
            chk("R8", "grp_rst_n[6]", {6'd0, grp_rst_n[6]}, 7'd1);
            chk("R3", "host_oe", {6'd0, host_oe}, {6'd0, !m_act});
            chk("R4", "slv_abort", {6'd0, slv_abort}, {6'd0, m_abort});
            chk("R5", "slv_active", {6'd0, slv_active}, {6'd0, m_active});
            chk("R5", "slv_ready", {6'd0, slv_ready}, {6'd0, 1'(m_cnt == HOLD)});
            chk("R6", "sw_rst_bit", {6'd0, sw_rst_bit}, {6'd0, m_sw});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic at_edge();
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            done = 1; bad++; vecs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin : stim
        // Power-up pin reset; check the reset state (R2, R3, R8)
        rst_pin_n = 1'b0;
        cyc(11);
        at_edge();
        chk("R2", "grp_rst_n in reset", grp_rst_n, 7'b100_0000);
        chk("R3", "host_oe in reset", {6'd0, host_oe}, 7'd0);
        chk("R5", "slv_ready in reset", {6'd0, slv_ready}, 7'd0);
        @(negedge clk);
        rst_pin_n = 1'b1;
        slv_req   = 1'b1;
        // Holdoff: no start on edges 0..3 after release, start on edge 4 (R5)
        for (int i = 0; i < HOLD; i++) begin
            at_edge();
            chk("R5", "slv_active during holdoff", {6'd0, slv_active}, 7'd0);
        end
        at_edge();
        chk("R5", "slv_active after holdoff", {6'd0, slv_active}, 7'd1);
        @(negedge clk);
        slv_req = 1'b0;

        // 7-cycle pulse is ignored (R1)
        rst_pin_n = 1'b0;
        cyc(MINP - 1);
        rst_pin_n = 1'b1;
        at_edge();
        chk("R1", "hw_rst_active short pulse", {6'd0, hw_rst_active}, 7'd0);
        chk("R1", "slv_active survives short pulse", {6'd0, slv_active}, 7'd1);
        chk("R1", "grp_rst_n short pulse", grp_rst_n, 7'h7F);

        // 8-cycle pulse qualifies and drops the open cycle (R2, R4)
        @(negedge clk);
        rst_pin_n = 1'b0;
        cyc(MINP - 1);
        at_edge();
        chk("R2", "hw_rst_active at 8th low", {6'd0, hw_rst_active}, 7'd1);
        chk("R4", "slv_active dropped", {6'd0, slv_active}, 7'd0);
        chk("R4", "slv_abort pulse", {6'd0, slv_abort}, 7'd1);
        at_edge();
        chk("R4", "slv_abort one cycle", {6'd0, slv_abort}, 7'd0);
        @(negedge clk);
        rst_pin_n = 1'b1;
        cyc(HOLD + 2);

        // Software reset set and held (R6, R7, R8)
        sw_wr_en = 1'b1; sw_wr_data = 1'b1;
        @(negedge clk);
        sw_wr_en = 1'b0; sw_wr_data = 1'b0;
        at_edge();
        chk("R7", "grp_rst_n under sw reset", grp_rst_n, 7'b111_1100);
        cyc(10);
        at_edge();
        chk("R6", "sw_rst_bit held", {6'd0, sw_rst_bit}, 7'd1);

        // Pin reset clears the bit; writes during it are ignored (R6)
        @(negedge clk);
        rst_pin_n = 1'b0;
        cyc(MINP + 2);
        sw_wr_en = 1'b1; sw_wr_data = 1'b1;
        @(negedge clk);
        sw_wr_en = 1'b0; sw_wr_data = 1'b0;
        at_edge();
        chk("R6", "write ignored in pin reset", {6'd0, sw_rst_bit}, 7'd0);
        @(negedge clk);
        rst_pin_n = 1'b1;
        cyc(HOLD + 1);

        // Set then clear by write; retained group untouched (R6, R8)
        sw_wr_en = 1'b1; sw_wr_data = 1'b1;
        @(negedge clk);
        sw_wr_data = 1'b0;
        @(negedge clk);
        sw_wr_en = 1'b0;
        at_edge();
        chk("R6", "sw_rst_bit cleared by write", {6'd0, sw_rst_bit}, 7'd0);
        chk("R8", "retained group", {6'd0, grp_rst_n[6]}, 7'd1);

        // Normal slave cycle ends without abort (R5)
        @(negedge clk);
        slv_req = 1'b1;
        @(negedge clk);
        slv_req = 1'b0;
        slv_end = 1'b1;
        @(negedge clk);
        slv_end = 1'b0;
        at_edge();
        chk("R5", "slave ended", {6'd0, slv_active}, 7'd0);
        chk("R4", "no abort on normal end", {6'd0, slv_abort}, 7'd0);

        cyc(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule